// File: doc/BRIEF.md
# Square-Wave Tone Voice with Frequency Sweep

This block is one tone voice of a sound unit. It produces a 4-bit amplitude sample that follows an eight-step rectangular waveform. Software picks one of four duty shapes, an 11-bit pitch code, a volume envelope that ramps up or down, a frequency sweep that moves the pitch by a shifted copy of itself, and an optional length counter that silences the voice after a set number of length ticks. A channel-active flag shows whether the voice is sounding.

Five byte registers are written over a simple write-only register bus. Three single-cycle tick inputs come from an external frame sequencer and pace the length counter (256 Hz), the sweep (128 Hz) and the envelope (64 Hz). Writing the control register with its restart bit set starts the voice again. A synchronous clear input returns the whole voice, including its registers, to the reset state. Mixing, panning and conversion to analog are done elsewhere.

Top module: `sqwave_voice`

## Requirements
- R1: Register map on `busAddr`: 0 = sweep (bits 6-4 sweep period, bit 3 = 1 subtract / 0 add, bits 2-0 shift), 1 = shape/length (bits 7-6 duty code, bits 5-0 length value), 2 = envelope (bits 7-4 start volume, bit 3 = 1 up / 0 down, bits 2-0 envelope period), 3 = pitch bits 7-0, 4 = control (bit 7 restart, bit 6 length enable, bits 2-0 pitch bits 10-8). A write takes effect at the clock edge where `busWrEn` is high.
- R2: Duty code 0, 1, 2, 3 select the step patterns 00000001, 10000001, 10000111 and 01111110, read left to right as steps 0 to 7.
- R3: Each waveform step lasts (2048 - pitch) x CLK_PER_UNIT clocks; a restart returns to step 0; `sampleOut` equals the current volume when the pattern bit of the current step is 1 and 0 otherwise.
- R4: Writing register 1 loads the length counter with 64 - length value; with length enabled, each length tick decrements a nonzero counter, and the tick that brings it to 0 makes the voice inactive.
- R5: With the length enable bit clear, length ticks leave the counter and the active flag untouched; setting the enable later without a restart lets the retained count expire.
- R6: A restart sets `chanActive` two clock edges after the write, reloads the volume from the start volume, reloads the envelope, sweep and step timers, latches the pitch, and reloads the length counter with 64 only if it is 0.
- R7: With a nonzero envelope period n, every n-th envelope tick moves the volume one step in the chosen direction, saturating at 0 and 15.
- R8: An envelope period of 0 freezes the volume.
- R9: With a nonzero sweep period n and the voice active, every n-th sweep tick computes pitch +/- (pitch >> shift); an addition result above 2047 makes the voice inactive (also with shift 0); otherwise, with a nonzero shift, the pitch takes the new value.
- R10: A sweep period of 0 makes sweep ticks have no effect.
- R11: Reset and `clrSync` make the voice inactive with a zero sample and clear all five registers, so that a later restart with no register writes sounds at volume 0.
- R12: While the voice is inactive `sampleOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrSync | input | 1 | Synchronous clear of the whole voice |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register index 0-4 |
| busWrData | input | 8 | Register write data |
| lenTick | input | 1 | Length-counter tick, one cycle wide |
| sweepTick | input | 1 | Sweep tick, one cycle wide |
| envTick | input | 1 | Envelope tick, one cycle wide |
| sampleOut | output | 4 | Amplitude sample |
| chanActive | output | 1 | Voice is sounding |

## Verification
The bench builds the voice with CLK_PER_UNIT = 2 instead of 4. With pitch code 2040, each step is 16 clocks, so all eight steps of every duty shape and the exact step boundary can be checked within a few hundred cycles. With pitch code 0, step 0 lasts 4096 clocks. That leaves time for long tick sequences, such as a full 64-tick length run after a restart, while `sampleOut` still shows the raw volume. Sweep overflow is reached from pitch 1024 with shift 1 in two steps, or with shift 0 in one step.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int FREQ_W  = 11;
  localparam int LEN_W   = 6;
  localparam int VOL_W   = 4;
  localparam int PER_W   = 3;
  localparam int SHIFT_W = 3;
  localparam int DUTY_W  = 2;
  localparam int ADDR_W  = 3;
  localparam int STEPS   = 8;
  localparam int POS_W   = $clog2(STEPS);

  localparam logic [ADDR_W-1:0] ADDR_SWEEP   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SHAPE   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENV     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PITCHLO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd4;

  typedef struct packed {
    logic [PER_W-1:0]   sweepPer;
    logic               sweepSub;
    logic [SHIFT_W-1:0] sweepShift;
    logic [DUTY_W-1:0]  duty;
    logic [LEN_W-1:0]   lenVal;
    logic [VOL_W-1:0]   envInit;
    logic               envUp;
    logic [PER_W-1:0]   envPer;
    logic [FREQ_W-1:0]  pitch;
    logic               lenEn;
  } voiceCfg_t;

  typedef struct packed {
    logic trigger;
    logic lenLoad;
    logic lenStep;
    logic envStep;
    logic sweepStep;
  } voiceStrb_t;
endpackage

// File: rtl/sqw_ctrl.sv
module sqw_ctrl import sqw_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              lenTick,
  input  logic              sweepTick,
  input  logic              envTick,
  output voiceCfg_t         cfg,
  output voiceStrb_t        strb
);
  logic hitCtrl;
  logic hitShape;

  assign hitCtrl  = wrEn && (addr == ADDR_CTRL);
  assign hitShape = wrEn && (addr == ADDR_SHAPE);

  // configuration storage, decoded by fixed byte layout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (clr) begin
      cfg <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_SWEEP: begin
          cfg.sweepPer   <= wrData[6:4];
          cfg.sweepSub   <= wrData[3];
          cfg.sweepShift <= wrData[2:0];
        end
        ADDR_SHAPE: begin
          cfg.duty   <= wrData[7:6];
          cfg.lenVal <= wrData[5:0];
        end
        ADDR_ENV: begin
          cfg.envInit <= wrData[7:4];
          cfg.envUp   <= wrData[3];
          cfg.envPer  <= wrData[2:0];
        end
        ADDR_PITCHLO: cfg.pitch[7:0] <= wrData;
        ADDR_CTRL: begin
          cfg.pitch[FREQ_W-1:8] <= wrData[2:0];
          cfg.lenEn             <= wrData[6];
        end
        default: ;
      endcase
    end
  end

  // strobes are registered so the datapath sees the updated configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb <= '0;
    end else if (clr) begin
      strb <= '0;
    end else begin
      strb.trigger   <= hitCtrl && wrData[7];
      strb.lenLoad   <= hitShape;
      strb.lenStep   <= lenTick;
      strb.envStep   <= envTick;
      strb.sweepStep <= sweepTick;
    end
  end
endmodule

// File: rtl/sqw_dp.sv
module sqw_dp import sqw_pkg::*; #(
  parameter int CLK_PER_UNIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  voiceCfg_t        cfg,
  input  voiceStrb_t       strb,
  output logic [VOL_W-1:0] sampleOut,
  output logic             chanActive
);
  localparam int FREQ_SPAN = 1 << FREQ_W;
  localparam int TMR_MAX   = FREQ_SPAN * CLK_PER_UNIT;
  localparam int TMR_W     = $clog2(TMR_MAX);
  localparam int LEN_SPAN  = 1 << LEN_W;
  localparam int LCNT_W    = LEN_W + 1;
  localparam logic [VOL_W-1:0] VOL_MAX = '1;
  localparam logic [STEPS-1:0] DUTY_PAT [4] =
    '{8'b00000001, 8'b10000001, 8'b10000111, 8'b01111110};

  function automatic logic [TMR_W-1:0] stepLen(input logic [FREQ_W-1:0] f);
    int p;
    p = (FREQ_SPAN - int'(f)) * CLK_PER_UNIT - 1;
    return TMR_W'(p);
  endfunction

  logic [TMR_W-1:0]   stepTmr;
  logic [POS_W-1:0]   dutyPos;
  logic [LCNT_W-1:0]  lenCnt;
  logic [VOL_W-1:0]   volume;
  logic [PER_W-1:0]   envCnt;
  logic [PER_W-1:0]   sweepCnt;
  logic [FREQ_W-1:0]  shadowPitch;
  logic [FREQ_W-1:0]  deltaPitch;
  logic [FREQ_W:0]    sumPitch;
  logic [FREQ_W-1:0]  newPitch;
  logic               sweepOvf;
  logic               sweepDue;
  logic               sweepKill;
  logic               lenExpire;
  logic               waveBit;

  // pitch sweep arithmetic
  always_comb begin
    deltaPitch = shadowPitch >> cfg.sweepShift;
    sumPitch   = {1'b0, shadowPitch} + {1'b0, deltaPitch};
    newPitch   = cfg.sweepSub ? (shadowPitch - deltaPitch) : sumPitch[FREQ_W-1:0];
    sweepOvf   = !cfg.sweepSub && sumPitch[FREQ_W];
  end

  assign sweepDue  = strb.sweepStep && chanActive && (cfg.sweepPer != '0)
                     && (sweepCnt <= PER_W'(1));
  assign sweepKill = sweepDue && sweepOvf;
  assign lenExpire = strb.lenStep && cfg.lenEn && (lenCnt == LCNT_W'(1));

  // step timer and waveform position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepTmr <= '0;
      dutyPos <= '0;
    end else if (clr) begin
      stepTmr <= '0;
      dutyPos <= '0;
    end else if (strb.trigger) begin
      stepTmr <= stepLen(cfg.pitch);
      dutyPos <= '0;
    end else if (chanActive) begin
      if (stepTmr == '0) begin
        stepTmr <= stepLen(shadowPitch);
        dutyPos <= dutyPos + POS_W'(1);
      end else begin
        stepTmr <= stepTmr - TMR_W'(1);
      end
    end
  end

  // R3
  duty_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !strb.trigger) |=> (dutyPos == $past(dutyPos) || dutyPos == $past(dutyPos) + POS_W'(1)));

  // length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCnt <= '0;
    end else if (clr) begin
      lenCnt <= '0;
    end else if (strb.lenLoad) begin
      lenCnt <= LCNT_W'(LEN_SPAN) - {1'b0, cfg.lenVal};
    end else if (strb.trigger) begin
      if (lenCnt == '0) lenCnt <= LCNT_W'(LEN_SPAN);
    end else if (strb.lenStep && cfg.lenEn && lenCnt != '0) begin
      lenCnt <= lenCnt - LCNT_W'(1);
    end
  end

  // R4
  len_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !strb.trigger && !strb.lenLoad) |=> (lenCnt <= $past(lenCnt)));

  // volume envelope
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volume <= '0;
      envCnt <= '0;
    end else if (clr) begin
      volume <= '0;
      envCnt <= '0;
    end else if (strb.trigger) begin
      volume <= cfg.envInit;
      envCnt <= cfg.envPer;
    end else if (strb.envStep && cfg.envPer != '0) begin
      if (envCnt <= PER_W'(1)) begin
        envCnt <= cfg.envPer;
        if (cfg.envUp && volume != VOL_MAX) volume <= volume + VOL_W'(1);
        else if (!cfg.envUp && volume != '0) volume <= volume - VOL_W'(1);
      end else begin
        envCnt <= envCnt - PER_W'(1);
      end
    end
  end

  // R7
  vol_slew_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !strb.trigger) |=> (volume == $past(volume) || volume == $past(volume) + VOL_W'(1)
                                 || volume == $past(volume) - VOL_W'(1)));

  // frequency sweep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPitch <= '0;
      sweepCnt    <= '0;
    end else if (clr) begin
      shadowPitch <= '0;
      sweepCnt    <= '0;
    end else if (strb.trigger) begin
      shadowPitch <= cfg.pitch;
      sweepCnt    <= cfg.sweepPer;
    end else if (strb.sweepStep && chanActive && cfg.sweepPer != '0) begin
      if (sweepDue) begin
        sweepCnt <= cfg.sweepPer;
        if (!sweepOvf && cfg.sweepShift != '0) shadowPitch <= newPitch;
      end else begin
        sweepCnt <= sweepCnt - PER_W'(1);
      end
    end
  end

  // active flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanActive <= 1'b0;
    end else if (clr) begin
      chanActive <= 1'b0;
    end else if (strb.trigger) begin
      chanActive <= 1'b1;
    end else if (lenExpire || sweepKill) begin
      chanActive <= 1'b0;
    end
  end

  // R6
  trig_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigger && !clr) |=> chanActive);

  // R11
  clr_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!chanActive && volume == '0 && lenCnt == '0));

  assign waveBit   = DUTY_PAT[cfg.duty][POS_W'(STEPS - 1) - dutyPos];
  assign sampleOut = (chanActive && waveBit) ? volume : '0;
endmodule

// File: rtl/sqwave_voice.sv
module sqwave_voice import sqw_pkg::*; #(
  parameter int CLK_PER_UNIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrSync,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              lenTick,
  input  logic              sweepTick,
  input  logic              envTick,
  output logic [VOL_W-1:0]  sampleOut,
  output logic              chanActive
);
  voiceCfg_t  cfg;
  voiceStrb_t strb;

  sqw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clr(clrSync),
    .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .lenTick(lenTick), .sweepTick(sweepTick), .envTick(envTick),
    .cfg(cfg), .strb(strb)
  );

  sqw_dp #(.CLK_PER_UNIT(CLK_PER_UNIT)) u_dp (
    .clk(clk), .rstN(rstN), .clr(clrSync),
    .cfg(cfg), .strb(strb),
    .sampleOut(sampleOut), .chanActive(chanActive)
  );

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrSync || !chanActive) |=> (!chanActive || sampleOut == '0 || $past(strb.trigger)) );
endmodule

// File: tb/test_sqwave_voice.sv
module test_sqwave_voice;
  localparam int UNIT = 2;
  localparam int P    = (2048 - 2040) * UNIT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrSync = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic lenTick = 1'b0;
  logic sweepTick = 1'b0;
  logic envTick = 1'b0;
  logic [3:0] sampleOut;
  logic chanActive;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sqwave_voice #(.CLK_PER_UNIT(UNIT)) i_sqwave_voice (
    .clk(clk), .rstN(rstN), .clrSync(clrSync), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .lenTick(lenTick),
    .sweepTick(sweepTick), .envTick(envTick),
    .sampleOut(sampleOut), .chanActive(chanActive)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
    @(negedge clk);
  endtask

  // which: 0 length, 1 sweep, 2 envelope
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) lenTick = 1'b1; else if (which == 1) sweepTick = 1'b1; else envTick = 1'b1;
      @(negedge clk);
      lenTick = 1'b0; sweepTick = 1'b0; envTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    checkVal("R11 reset sample", int'(sampleOut), 0);
    checkVal("R11 reset active", int'(chanActive), 0);
    checkVal("R12 idle sample", int'(sampleOut), 0);
  endtask

  task automatic runPattern(input logic [1:0] duty, input logic [7:0] pat, input string tag);
    busWrite(3'd1, {duty, 6'd0});
    busWrite(3'd4, 8'h87);
    for (int k = 0; k < 8; k++) begin
      checkVal(tag, int'(sampleOut), pat[7-k] ? 15 : 0);
      repeat (P) @(negedge clk);
    end
  endtask

  task automatic testDuty();
    busWrite(3'd2, 8'hF0);
    busWrite(3'd3, 8'hF8);
    runPattern(2'd2, 8'b10000111, "R2 R3 duty 50%");
    runPattern(2'd0, 8'b00000001, "R2 R3 duty 12.5%");
    runPattern(2'd1, 8'b10000001, "R2 R3 duty 25%");
    runPattern(2'd3, 8'b01111110, "R2 R3 duty 75%");
    busWrite(3'd1, 8'h80);
    busWrite(3'd4, 8'h87);
    checkVal("R6 active after restart", int'(chanActive), 1);
    repeat (P - 1) @(negedge clk);
    checkVal("R3 last clock of step 0", int'(sampleOut), 15);
    @(negedge clk);
    checkVal("R3 first clock of step 1", int'(sampleOut), 0);
  endtask

  task automatic testLength();
    busWrite(3'd2, 8'hF0);
    busWrite(3'd3, 8'h00);
    busWrite(3'd1, 8'h7E);
    busWrite(3'd4, 8'hC0);
    checkVal("R1 R6 sample at volume", int'(sampleOut), 15);
    pulse(0, 1);
    checkVal("R4 one tick left", int'(chanActive), 1);
    pulse(0, 1);
    checkVal("R4 length expired", int'(chanActive), 0);
    checkVal("R12 expired sample", int'(sampleOut), 0);
    busWrite(3'd4, 8'hC0);
    pulse(0, 63);
    checkVal("R6 length reloaded 64", int'(chanActive), 1);
    pulse(0, 1);
    checkVal("R6 full length expired", int'(chanActive), 0);
    busWrite(3'd1, 8'h7F);
    busWrite(3'd4, 8'h80);
    pulse(0, 3);
    checkVal("R5 disabled length ignored", int'(chanActive), 1);
    busWrite(3'd4, 8'h40);
    checkVal("R5 enable alone keeps active", int'(chanActive), 1);
    pulse(0, 1);
    checkVal("R5 retained count expires", int'(chanActive), 0);
  endtask

  task automatic testEnvelope();
    busWrite(3'd1, 8'h40);
    busWrite(3'd3, 8'h00);
    busWrite(3'd2, 8'hF1);
    busWrite(3'd4, 8'h80);
    pulse(2, 3);
    checkVal("R7 down three steps", int'(sampleOut), 12);
    busWrite(3'd2, 8'hE9);
    busWrite(3'd4, 8'h80);
    checkVal("R6 volume reload", int'(sampleOut), 14);
    pulse(2, 3);
    checkVal("R7 saturate at 15", int'(sampleOut), 15);
    busWrite(3'd2, 8'h11);
    busWrite(3'd4, 8'h80);
    pulse(2, 3);
    checkVal("R7 saturate at 0", int'(sampleOut), 0);
    busWrite(3'd2, 8'h70);
    busWrite(3'd4, 8'h80);
    pulse(2, 2);
    checkVal("R8 period 0 frozen", int'(sampleOut), 7);
    busWrite(3'd2, 8'h82);
    busWrite(3'd4, 8'h80);
    pulse(2, 1);
    checkVal("R7 period 2 first tick", int'(sampleOut), 8);
    pulse(2, 1);
    checkVal("R7 period 2 second tick", int'(sampleOut), 7);
  endtask

  task automatic testSweep();
    busWrite(3'd1, 8'h40);
    busWrite(3'd2, 8'hF0);
    busWrite(3'd3, 8'h00);
    busWrite(3'd0, 8'h11);
    busWrite(3'd4, 8'h84);
    pulse(1, 1);
    checkVal("R9 1024 to 1536 stays", int'(chanActive), 1);
    pulse(1, 1);
    checkVal("R9 overflow silences", int'(chanActive), 0);
    busWrite(3'd0, 8'h21);
    busWrite(3'd4, 8'h84);
    pulse(1, 3);
    checkVal("R9 period 2 after 3 ticks", int'(chanActive), 1);
    pulse(1, 1);
    checkVal("R9 period 2 after 4 ticks", int'(chanActive), 0);
    busWrite(3'd0, 8'h00);
    busWrite(3'd4, 8'h84);
    pulse(1, 2);
    checkVal("R10 period 0 no effect", int'(chanActive), 1);
    busWrite(3'd0, 8'h10);
    busWrite(3'd4, 8'h84);
    pulse(1, 1);
    checkVal("R9 shift 0 overflow", int'(chanActive), 0);
    busWrite(3'd3, 8'hFF);
    busWrite(3'd0, 8'h19);
    busWrite(3'd4, 8'h87);
    pulse(1, 5);
    checkVal("R9 subtract never silences", int'(chanActive), 1);
  endtask

  task automatic testClear();
    busWrite(3'd1, 8'h40);
    busWrite(3'd2, 8'hF0);
    busWrite(3'd3, 8'h00);
    busWrite(3'd4, 8'h80);
    checkVal("R6 active before clear", int'(chanActive), 1);
    @(negedge clk); clrSync = 1'b1;
    @(negedge clk); clrSync = 1'b0;
    checkVal("R11 clear inactive", int'(chanActive), 0);
    checkVal("R11 clear sample", int'(sampleOut), 0);
    busWrite(3'd4, 8'h80);
    checkVal("R11 restart after clear active", int'(chanActive), 1);
    checkVal("R11 registers cleared volume 0", int'(sampleOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDuty();
    testLength();
    testEnvelope();
    testSweep();
    testClear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule